// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block sits next to a CPU core and compresses what the core does in each cycle into a 4-bit status code, `pst`. The core raises one-cycle strobes when an instruction starts, when a taken branch starts, when it enters user mode, when a pulse or debug-write instruction starts, and when a return from exception starts. It holds level signals for exception processing, emulator-mode entry, the stopped state and the halted state. The code is registered, so it appears on the clock edge after the event is sampled. It does not have to match whatever bus transfer is in progress.

Some branches compute their target from a program register, so an external trace tool cannot work the target out from the program image. For these, the core also raises `br_variant` and presents the target address together with a byte count. The block then emits three things in order. First comes the taken-branch code. Next comes a byte-count code, which is issued in the first later cycle that carries no other status. Last, the low bytes of the address go out on the 4-bit `ddata` port, one nibble per clock, least significant nibble first.

A second such request that arrives while a transfer is under way is parked in a one-entry buffer. A third one is dropped, and the sticky `ovf` flag is raised.

Top module: `trace_status_enc`

## Requirements
- R1: After reset, and while `rst_n` is low, `pst` is 0, `ddata` is 0 and `ovf` is 0.
- R2: With no level condition active, the edge that samples a strobe drives one code, chosen by this priority: taken branch 5, then return from exception 7, then pulse/debug-write 4, then user-mode entry 3, then instruction start 1. With no strobe and no pending byte-count code, the code is 0.
- R3: The level conditions outrank every strobe. Their codes are halted F, stopped E, emulator entry D and exception C, in that priority. A code is driven on every cycle its condition is sampled high, and the data port keeps shifting meanwhile.
- R4: The codes 2 and 6 never appear on `pst`.
- R5: A taken branch with `br_variant` high and a byte selection n of 1 to 4 gives code 5. Later, a count code 7+n (8, 9, A or B) follows. It is issued in the first following cycle with no strobe and no level condition. Selection values 5 to 7 count as 4.
- R6: From the cycle after the count code, `ddata` carries the low 8n bits of the captured address over 2n cycles, least significant nibble first. Outside these windows `ddata` is 0.
- R7: A byte selection of 0, or a branch with `br_variant` low, gives code 5 only. No count code follows and no data is sent.
- R8: A request that arrives while another address is still waiting or shifting is kept in a one-entry buffer. Its count code and data follow once the current transfer ends. A request that arrives in the final nibble cycle of a transfer, with the buffer empty, is taken directly.
- R9: A request that finds the buffer full, while the current transfer is not in its final nibble cycle, is dropped. It then sets `ovf`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_insn | input | 1 | Instruction start strobe |
| ev_branch | input | 1 | Taken branch strobe |
| ev_user | input | 1 | User-mode entry strobe |
| ev_pulse | input | 1 | Pulse / debug-write instruction strobe |
| ev_rte | input | 1 | Return-from-exception strobe |
| ev_exc | input | 1 | Exception processing (level) |
| ev_emu | input | 1 | Emulator-mode entry (level) |
| ev_stop | input | 1 | Stopped, awaiting interrupt (level) |
| ev_halt | input | 1 | Halted (level) |
| br_variant | input | 1 | Branch target is register-derived; capture it |
| br_target | input | ADDR_W | Branch target address |
| br_bytes | input | 3 | Number of target bytes to show (0 to 4, larger values clamp to 4) |
| pst | output | 4 | Registered processor status code |
| ddata | output | 4 | Registered debug data nibble |
| ovf | output | 1 | Sticky dropped-request flag |

## Verification
Two functions can claim the same cycle. One is a pending byte-count announcement. The other is a fresh status strobe, either from a later branch or from a run of instruction starts. The bench provokes this by issuing strobes on the cycles right after a variant branch, and by filling the buffer with back-to-back branches. It then expects the strobe's code to win, the count code to be deferred to the first empty slot, and the address nibbles to be rebuilt intact afterwards. A monitor reassembles every announced window and counts any nonzero data nibble outside a window.

// File: rtl/tse_pkg.sv
package tse_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'h0,
    ST_INSN   = 4'h1,
    ST_USER   = 4'h3,
    ST_PULSE  = 4'h4,
    ST_BRANCH = 4'h5,
    ST_RTE    = 4'h7,
    ST_EXC    = 4'hC,
    ST_EMU    = 4'hD,
    ST_STOP   = 4'hE,
    ST_HALT   = 4'hF
  } st_code_e;

  localparam int BSEL_W = 3;

  // Limit a byte selection to what the address width can supply.
  function automatic logic [BSEL_W-1:0] clamp_bytes(input logic [BSEL_W-1:0] sel,
                                                    input int max_b);
    if (int'(sel) > max_b) return BSEL_W'(max_b);
    return sel;
  endfunction

  // Status code that announces an n-byte transfer (n >= 1).
  function automatic logic [3:0] count_code(input logic [BSEL_W-1:0] nb);
    return 4'd7 + {1'b0, nb};
  endfunction

  // Number of nibble cycles for an n-byte transfer.
  function automatic logic [3:0] nibble_total(input logic [BSEL_W-1:0] nb);
    return {nb, 1'b0};
  endfunction

endpackage

// File: rtl/tse_status_sel.sv
module tse_status_sel
  import tse_pkg::*;
(
  input  logic              ev_insn,
  input  logic              ev_branch,
  input  logic              ev_user,
  input  logic              ev_pulse,
  input  logic              ev_rte,
  input  logic              ev_exc,
  input  logic              ev_emu,
  input  logic              ev_stop,
  input  logic              ev_halt,
  input  logic              ann_pending,
  input  logic [BSEL_W-1:0] ann_bytes,
  output logic [3:0]        code_nxt,
  output logic              held,
  output logic              ann_fire,
  output logic              branch_won
);

  logic any_strobe;

  assign held       = ev_halt | ev_stop | ev_emu | ev_exc;
  assign any_strobe = ev_insn | ev_branch | ev_user | ev_pulse | ev_rte;
  assign ann_fire   = ann_pending & ~held & ~any_strobe;
  assign branch_won = ev_branch & ~held;

  always_comb begin
    code_nxt = ST_IDLE;
    if (ev_halt)        code_nxt = ST_HALT;
    else if (ev_stop)   code_nxt = ST_STOP;
    else if (ev_emu)    code_nxt = ST_EMU;
    else if (ev_exc)    code_nxt = ST_EXC;
    else if (ev_branch) code_nxt = ST_BRANCH;
    else if (ev_rte)    code_nxt = ST_RTE;
    else if (ev_pulse)  code_nxt = ST_PULSE;
    else if (ev_user)   code_nxt = ST_USER;
    else if (ev_insn)   code_nxt = ST_INSN;
    else if (ann_pending) code_nxt = count_code(ann_bytes);
  end

endmodule

// File: rtl/tse_target_q.sv
module tse_target_q
  import tse_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BSEL_W-1:0] req_bytes,
  input  logic              ann_fire,
  output logic              ann_pending,
  output logic [BSEL_W-1:0] ann_bytes,
  output logic [3:0]        ddata,
  output logic              ovf
);

  localparam int CNT_W = 4;

  logic              cur_v, cur_sh;
  logic [ADDR_W-1:0] cur_addr;
  logic [BSEL_W-1:0] cur_nb;
  logic [CNT_W-1:0]  cnt;
  logic              buf_v;
  logic [ADDR_W-1:0] buf_addr;
  logic [BSEL_W-1:0] buf_nb;
  logic [3:0]        ddata_q;
  logic              ovf_q;

  // Named events for the assertions.
  logic shifting, finishing, drop;
  assign shifting    = cur_v & cur_sh;
  assign finishing   = shifting & (cnt == CNT_W'(1));
  assign drop        = req & cur_v & ~finishing & buf_v;
  assign ann_pending = cur_v & ~cur_sh;
  assign ann_bytes   = cur_nb;
  assign ddata       = ddata_q;
  assign ovf         = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v    <= 1'b0;
      cur_sh   <= 1'b0;
      cur_addr <= '0;
      cur_nb   <= '0;
      cnt      <= '0;
      buf_v    <= 1'b0;
      buf_addr <= '0;
      buf_nb   <= '0;
      ddata_q  <= 4'h0;
      ovf_q    <= 1'b0;
    end else begin
      ddata_q <= 4'h0;
      if (shifting) begin
        ddata_q  <= cur_addr[3:0];
        cur_addr <= cur_addr >> 4;
        cnt      <= cnt - CNT_W'(1);
      end
      if (ann_fire) begin
        cur_sh <= 1'b1;
        cnt    <= nibble_total(cur_nb);
      end
      if (!cur_v) begin
        if (req) begin
          cur_v    <= 1'b1;
          cur_sh   <= 1'b0;
          cur_addr <= req_addr;
          cur_nb   <= req_bytes;
        end
      end else if (finishing) begin
        if (buf_v) begin
          cur_v    <= 1'b1;
          cur_sh   <= 1'b0;
          cur_addr <= buf_addr;
          cur_nb   <= buf_nb;
          buf_v    <= req;
          if (req) begin
            buf_addr <= req_addr;
            buf_nb   <= req_bytes;
          end
        end else if (req) begin
          cur_v    <= 1'b1;
          cur_sh   <= 1'b0;
          cur_addr <= req_addr;
          cur_nb   <= req_bytes;
        end else begin
          cur_v  <= 1'b0;
          cur_sh <= 1'b0;
        end
      end else if (req) begin
        if (!buf_v) begin
          buf_v    <= 1'b1;
          buf_addr <= req_addr;
          buf_nb   <= req_bytes;
        end
      end
      if (drop) ovf_q <= 1'b1;
    end
  end

  // R8: the buffer is only ever occupied behind a live current entry
  a_r8_buf_behind_cur: assert property (@(posedge clk) disable iff (!rst_n)
    buf_v |-> cur_v);

  // R9: once raised, the overflow flag never clears without reset
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R9: a dropped request raises the flag on the next cycle
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);

  // R6: with nothing shifting, the next data nibble is zero
  a_r6_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |=> (ddata_q == 4'h0));

  // R5: an announcement never coincides with an active shift
  a_r5_no_ann_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
    ann_fire |-> !shifting);

endmodule

// File: rtl/trace_status_enc.sv
module trace_status_enc
  import tse_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_insn,
  input  logic              ev_branch,
  input  logic              ev_user,
  input  logic              ev_pulse,
  input  logic              ev_rte,
  input  logic              ev_exc,
  input  logic              ev_emu,
  input  logic              ev_stop,
  input  logic              ev_halt,
  input  logic              br_variant,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [2:0]        br_bytes,
  output logic [3:0]        pst,
  output logic [3:0]        ddata,
  output logic              ovf
);

  localparam int MAX_BYTES = (ADDR_W / 8 > 4) ? 4 : ADDR_W / 8;

  logic [3:0]        code_nxt;
  logic              held, ann_fire, branch_won, ann_pending;
  logic [BSEL_W-1:0] ann_bytes, sel_bytes;
  logic              req;
  logic [3:0]        pst_q;

  assign sel_bytes = clamp_bytes(br_bytes, MAX_BYTES);
  assign req       = branch_won & br_variant & (sel_bytes != '0);

  tse_status_sel u_sel (
    .ev_insn    (ev_insn),
    .ev_branch  (ev_branch),
    .ev_user    (ev_user),
    .ev_pulse   (ev_pulse),
    .ev_rte     (ev_rte),
    .ev_exc     (ev_exc),
    .ev_emu     (ev_emu),
    .ev_stop    (ev_stop),
    .ev_halt    (ev_halt),
    .ann_pending(ann_pending),
    .ann_bytes  (ann_bytes),
    .code_nxt   (code_nxt),
    .held       (held),
    .ann_fire   (ann_fire),
    .branch_won (branch_won)
  );

  tse_target_q #(.ADDR_W(ADDR_W)) u_q (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_addr   (br_target),
    .req_bytes  (sel_bytes),
    .ann_fire   (ann_fire),
    .ann_pending(ann_pending),
    .ann_bytes  (ann_bytes),
    .ddata      (ddata),
    .ovf        (ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pst_q <= ST_IDLE;
    else        pst_q <= code_nxt;
  end
  assign pst = pst_q;

  // R4: reserved codes never leave the block
  a_r4_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (pst != 4'h2) && (pst != 4'h6));

  // R3: a halt condition shows as code F on the following cycle
  a_r3_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> (pst == 4'hF));

  // R3: any level condition keeps count codes off the next cycle
  a_r3_held_blocks_ann: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (pst >= 4'hC));

  // R5: a fired announcement appears as a count code next cycle
  a_r5_ann_code: assert property (@(posedge clk) disable iff (!rst_n)
    ann_fire |=> (pst >= 4'h8 && pst <= 4'hB));

  // R2: a quiet cycle with nothing pending drives code 0
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && !ev_insn && !ev_branch && !ev_user && !ev_pulse && !ev_rte && !ann_pending)
      |=> (pst == 4'h0));

endmodule

// File: tb/sim_trace_status_enc.sv
`timescale 1ns/1ps
module sim_trace_status_enc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_insn, ev_branch, ev_user, ev_pulse, ev_rte;
  logic        ev_exc, ev_emu, ev_stop, ev_halt;
  logic        br_variant;
  logic [31:0] br_target;
  logic [2:0]  br_bytes;
  logic [3:0]  pst, ddata;
  logic        ovf;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  trace_status_enc #(.ADDR_W(32)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_insn(ev_insn), .ev_branch(ev_branch), .ev_user(ev_user),
    .ev_pulse(ev_pulse), .ev_rte(ev_rte), .ev_exc(ev_exc), .ev_emu(ev_emu),
    .ev_stop(ev_stop), .ev_halt(ev_halt), .br_variant(br_variant),
    .br_target(br_target), .br_bytes(br_bytes),
    .pst(pst), .ddata(ddata), .ovf(ovf)
  );

  // Monitor: rebuilds every announced address window; counts stray nibbles.
  logic [31:0] rx_addr[$];
  int          rx_nb[$];
  int          stray = 0;
  int          win = 0, k = 0, curn = 0;
  logic [31:0] acc = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      win = 0;
    end else begin
      if (win > 0) begin
        acc = acc | (32'(ddata) << (4 * k));
        k++;
        win--;
        if (win == 0) begin
          rx_addr.push_back(acc);
          rx_nb.push_back(curn);
        end
      end else if (ddata != 4'h0) begin
        stray++;
      end
      if (pst >= 4'h8 && pst <= 4'hB) begin
        if (win > 0) stray++;
        curn = int'(pst) - 7;
        win  = 2 * curn;
        k    = 0;
        acc  = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    {ev_insn, ev_branch, ev_user, ev_pulse, ev_rte} = '0;
    {ev_exc, ev_emu, ev_stop, ev_halt} = '0;
    br_variant = 1'b0;
    br_target  = '0;
    br_bytes   = '0;
  endtask

  // bit0 insn, 1 branch, 2 user, 3 pulse, 4 rte, 5 exc, 6 emu, 7 stop, 8 halt
  task automatic set_ev(input logic [8:0] v);
    ev_insn = v[0]; ev_branch = v[1]; ev_user = v[2]; ev_pulse = v[3];
    ev_rte  = v[4]; ev_exc    = v[5]; ev_emu  = v[6]; ev_stop  = v[7];
    ev_halt = v[8];
  endtask

  function automatic int exp_code(input logic [8:0] v);
    int order[9] = '{8, 7, 6, 5, 1, 4, 3, 2, 0};
    int codes[9] = '{15, 14, 13, 12, 5, 7, 4, 3, 1};
    for (int i = 0; i < 9; i++)
      if (v[order[i]]) return codes[i];
    return 0;
  endfunction

  function automatic int eff_bytes(input int sel);
    return (sel > 4) ? 4 : sel;
  endfunction

  function automatic logic [31:0] low_bytes(input logic [31:0] a, input int n);
    logic [63:0] m;
    m = (64'd1 << (8 * n)) - 64'd1;
    return a & m[31:0];
  endfunction

  task automatic branch(input logic [31:0] a, input int sel);
    quiet();
    ev_branch  = 1'b1;
    br_variant = 1'b1;
    br_target  = a;
    br_bytes   = 3'(sel);
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 1'b0;
    tick();
    tick();
    chk(pst == 4'h0 && ddata == 4'h0 && ovf == 1'b0, "R1 reset state",
        {pst, ddata, 3'b0, ovf}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    quiet();
    do_reset();
    tick();
    chk(pst == 4'h0, "R2 idle code", pst, 0);

    // R2 R3 R4: every strobe/level combination, plain branches only
    for (int v = 0; v < 512; v++) begin
      set_ev(9'(v));
      tick();
      chk(pst == 4'(exp_code(9'(v))), "R2/R3 priority", pst, exp_code(9'(v)));
      chk(pst != 4'h2 && pst != 4'h6, "R4 reserved", pst, exp_code(9'(v)));
    end
    quiet();
    tick();
    chk(rx_addr.size() == 0 && stray == 0, "R7 no data for plain branch",
        rx_addr.size() + stray, 0);

    // R5 R6 R7: every byte selection
    for (int s = 0; s < 8; s++) begin
      int n0, s0, nb;
      logic [31:0] a;
      a  = 32'h9E37_79B9 ^ (32'h1357_2468 * 32'(s + 1));
      nb = eff_bytes(s);
      n0 = rx_addr.size();
      s0 = stray;
      branch(a, s);
      tick();
      chk(pst == 4'h5, "R5 branch code", pst, 5);
      quiet();
      tick();
      if (nb > 0) chk(pst == 4'(7 + nb), "R5 count code", pst, 7 + nb);
      else        chk(pst == 4'h0, "R7 no count code", pst, 0);
      repeat (12) tick();
      if (nb > 0) begin
        chk(rx_addr.size() == n0 + 1, "R6 window seen", rx_addr.size() - n0, 1);
        if (rx_addr.size() == n0 + 1) begin
          chk(rx_addr[n0] == low_bytes(a, nb), "R6 nibble order", rx_addr[n0], low_bytes(a, nb));
          chk(rx_nb[n0] == nb, "R5 byte count", rx_nb[n0], nb);
        end
      end else begin
        chk(rx_addr.size() == n0, "R7 no window", rx_addr.size() - n0, 0);
      end
      chk(stray == s0, "R6 idle data zero", stray - s0, 0);
    end

    // R5: announcement deferred by instruction strobes
    begin
      int n0;
      n0 = rx_addr.size();
      branch(32'hC0DE_4A71, 2);
      tick();
      quiet();
      ev_insn = 1'b1;
      for (int i = 0; i < 3; i++) begin
        tick();
        chk(pst == 4'h1, "R5 strobe beats announcement", pst, 1);
      end
      quiet();
      tick();
      chk(pst == 4'h9, "R5 deferred count code", pst, 9);
      repeat (8) tick();
      chk(rx_addr.size() == n0 + 1 && rx_addr[n0] == 32'h0000_4A71,
          "R6 deferred data", rx_addr[rx_addr.size() - 1], 32'h4A71);
    end

    // R3: halt while shifting; data keeps flowing
    begin
      int n0;
      n0 = rx_addr.size();
      branch(32'h8765_4321, 4);
      tick();
      quiet();
      tick();
      chk(pst == 4'hB, "R5 four-byte count", pst, 11);
      ev_halt = 1'b1;
      for (int i = 0; i < 4; i++) begin
        tick();
        chk(pst == 4'hF, "R3 halt held", pst, 15);
      end
      quiet();
      repeat (8) tick();
      chk(rx_addr.size() == n0 + 1 && rx_addr[n0] == 32'h8765_4321,
          "R3 shift continues under halt", rx_addr[rx_addr.size() - 1], 32'h8765_4321);
    end

    // R8: second request during a shift is buffered
    begin
      int n0;
      n0 = rx_addr.size();
      branch(32'h0000_00A7, 1);
      tick();
      quiet();
      tick();
      branch(32'h0000_003C, 1);
      tick();
      quiet();
      repeat (10) tick();
      chk(rx_addr.size() == n0 + 2, "R8 both delivered", rx_addr.size() - n0, 2);
      if (rx_addr.size() == n0 + 2)
        chk(rx_addr[n0] == 32'hA7 && rx_addr[n0 + 1] == 32'h3C, "R8 order",
            rx_addr[n0 + 1], 32'h3C);
      chk(ovf == 1'b0, "R8 no overflow", ovf, 0);
    end

    // R8: request in final nibble cycle, buffer empty, is taken directly
    begin
      int n0;
      n0 = rx_addr.size();
      branch(32'h0000_005E, 1);
      tick();
      quiet();
      tick();
      tick();
      branch(32'h0000_00D2, 1);
      tick();
      quiet();
      repeat (10) tick();
      chk(rx_addr.size() == n0 + 2 && rx_addr[n0 + 1] == 32'hD2,
          "R8 final-cycle request", rx_addr[rx_addr.size() - 1], 32'hD2);
      chk(ovf == 1'b0, "R8 final-cycle no overflow", ovf, 0);
    end

    // R9: third request while buffer full is dropped
    begin
      int n0;
      n0 = rx_addr.size();
      branch(32'h0000_0011, 1);
      tick();
      branch(32'h0000_0022, 1);
      tick();
      branch(32'h0000_0033, 1);
      tick();
      quiet();
      repeat (12) tick();
      chk(rx_addr.size() == n0 + 2, "R9 third dropped", rx_addr.size() - n0, 2);
      if (rx_addr.size() == n0 + 2)
        chk(rx_addr[n0] == 32'h11 && rx_addr[n0 + 1] == 32'h22, "R9 survivors",
            rx_addr[n0 + 1], 32'h22);
      chk(ovf == 1'b1, "R9 overflow set", ovf, 1);
      repeat (5) tick();
      chk(ovf == 1'b1, "R9 overflow sticky", ovf, 1);
    end

    chk(stray == 0, "R6 no stray nibbles", stray, 0);
    do_reset();
    tick();
    chk(ovf == 1'b0, "R1 overflow cleared by reset", ovf, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule